// File: doc/BRIEF.md
# Host Mailbox with Paired DMA Requests

This block is the slave end of a host port on a 32-bit external bus. An outside master writes words into a host-side transmit holding register. Each word then moves by itself into a local receive register, where the local processor or a local DMA engine collects it. In the other direction, the local side places a word into a host-side receive holding register, and the master reads it from there.

One active-low request line goes back to the master and can drive its DMA service request input. It goes low when the transmit holding register has room, if transmit requests are enabled. It also goes low when the receive holding register holds a word, if receive requests are enabled. A local full flag on the transfer register doubles as the local DMA request to drain it. Host accesses are qualified by an active-low select and a read/write strobe. Each cycle with the select low counts as one access.

Top module: `hi_mbox`

## Requirements
- R1: After reset, hreq_no is high, ldma_req_o is low, both request enables are clear, and the status register reads 0x00000004.
- R2: A host write (hsel_ni low, hwrite_i high) to address 0 loads the transmit holding register when it is empty, and marks it full. A write while it is full is ignored, and the word already held is kept.
- R3: On the clock after the transmit holding register fills, if the local full flag is clear, the word moves to the local register lrdata_o. In that same step the local full flag sets and the transmit holding register becomes empty again.
- R4: While the local full flag is set, the local register keeps its value. Any word waiting in the transmit holding register stays there.
- R5: ldma_req_o equals the local full flag. A pulse on lrd_i clears it on the next edge.
- R6: hreq_no is low whenever the transmit holding register is empty and the transmit request enable (status bit 0) is set.
- R7: A local write (lwr_i) loads the receive holding register and marks it full, but only when it is empty. While it is full and the receive request enable (status bit 1) is set, hreq_no is low.
- R8: A host read of address 0 returns the receive holding register and clears its full flag.
- R9: Address 1 is the status register. A host write sets the enables from bits [1:0]. A read returns bit 0 transmit enable, bit 1 receive enable, bit 2 transmit-empty, bit 3 receive-full and bit 4 local-full, with all other bits zero.
- R10: Nothing changes state while hsel_ni is high. Addresses other than 0 and 1 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_ni | input | 1 | Host select, active low, one access per selected cycle |
| hwrite_i | input | 1 | Host direction, 1 = write |
| haddr_i | input | 4 | Host register select (address bits 5..2) |
| hwdata_i | input | 32 | Host write data |
| hrdata_o | output | 32 | Host read data for the selected register |
| hreq_no | output | 1 | Host request / master DMA request, active low |
| lrd_i | input | 1 | Local read strobe of the local register |
| lrdata_o | output | 32 | Local register contents |
| lwr_i | input | 1 | Local write strobe of the receive holding register |
| lwdata_i | input | 32 | Local write data |
| ldma_req_o | output | 1 | Local DMA request (local register full) |

## Verification
The assertions assume that every host access lasts one selected cycle. They also assume that the local strobes are single-cycle pulses that are synchronous to clk_i and never unknown after reset. The bench drives every input on the falling edge. It holds each strobe high for exactly one rising edge and returns hsel_ni high between accesses. It samples the outputs on the falling edge that follows the rising edge at which a change must appear.

// File: rtl/hi_mbox_pkg.sv
package hi_mbox_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_CSR  = 4'd1;
  localparam int CSR_TREQ = 0;
  localparam int CSR_RREQ = 1;
  localparam int CSR_TXDE = 2;
  localparam int CSR_RXF  = 3;
  localparam int CSR_HRDF = 4;
  localparam int CSR_W    = 5;
endpackage

// File: rtl/hi_mbox_decode.sv
module hi_mbox_decode
  import hi_mbox_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          sel_ni,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  output logic          data_sel_o,
  output logic          csr_sel_o,
  output logic          tx_wr_o,
  output logic          rx_rd_o,
  output logic          csr_wr_o
);
  always_comb begin
    data_sel_o = (addr_i == OFS_DATA);
    csr_sel_o  = (addr_i == OFS_CSR);
    tx_wr_o    = !sel_ni &&  write_i && data_sel_o;
    rx_rd_o    = !sel_ni && !write_i && data_sel_o;
    csr_wr_o   = !sel_ni &&  write_i && csr_sel_o;
  end
endmodule

// File: rtl/hi_mbox_tx_path.sv
module hi_mbox_tx_path #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          lrd_i,
  output logic [DW-1:0] hrx_o,
  output logic          hrdf_o,
  output logic          txde_o
);
  logic [DW-1:0] tx_q, hrx_q;
  logic          tx_full_q, hrdf_q;
  logic          move;

  // move only into an empty local register
  assign move = tx_full_q && !hrdf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      hrx_q     <= '0;
      tx_full_q <= 1'b0;
      hrdf_q    <= 1'b0;
    end else begin
      if (move) begin
        hrx_q     <= tx_q;
        hrdf_q    <= 1'b1;
        tx_full_q <= 1'b0;
      end else begin
        if (tx_wr_i && !tx_full_q) begin
          tx_q      <= wdata_i;
          tx_full_q <= 1'b1;
        end
        if (lrd_i) hrdf_q <= 1'b0;
      end
    end
  end

  assign hrx_o  = hrx_q;
  assign hrdf_o = hrdf_q;
  assign txde_o = !tx_full_q;

  a_r2_tx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && !tx_full_q) |=> (tx_full_q && tx_q == $past(wdata_i)));
  a_r2_tx_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_q && hrdf_q) |=> $stable(tx_q));
  a_r3_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_q && !hrdf_q) |=> (hrdf_q && !tx_full_q && hrx_q == $past(tx_q)));
  a_r4_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hrdf_q && !lrd_i) |=> (hrdf_q && $stable(hrx_q)));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hrdf_q && lrd_i) |=> !hrdf_q);
endmodule

// File: rtl/hi_mbox_rx_path.sv
module hi_mbox_rx_path #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lwr_i,
  input  logic [DW-1:0] lwdata_i,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_o,
  output logic          rx_full_o
);
  logic [DW-1:0] rx_q;
  logic          rx_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_full_q <= 1'b0;
    end else if (rx_full_q) begin
      if (rx_rd_i) rx_full_q <= 1'b0;
    end else if (lwr_i) begin
      rx_q      <= lwdata_i;
      rx_full_q <= 1'b1;
    end
  end

  assign rx_o      = rx_q;
  assign rx_full_o = rx_full_q;

  a_r7_rx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lwr_i && !rx_full_q) |=> (rx_full_q && rx_q == $past(lwdata_i)));
  a_r7_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_q && !rx_rd_i) |=> (rx_full_q && $stable(rx_q)));
  a_r8_rx_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_q && rx_rd_i) |=> !rx_full_q);
endmodule

// File: rtl/hi_mbox.sv
module hi_mbox
  import hi_mbox_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsel_ni,
  input  logic          hwrite_i,
  input  logic [AW-1:0] haddr_i,
  input  logic [DW-1:0] hwdata_i,
  output logic [DW-1:0] hrdata_o,
  output logic          hreq_no,
  input  logic          lrd_i,
  output logic [DW-1:0] lrdata_o,
  input  logic          lwr_i,
  input  logic [DW-1:0] lwdata_i,
  output logic          ldma_req_o
);
  localparam int PAD_W = DW - CSR_W;

  logic          data_sel, csr_sel, tx_wr, rx_rd, csr_wr;
  logic          hrdf, txde, rx_full;
  logic [DW-1:0] rx_word;
  logic          treq_q, rreq_q;
  logic [CSR_W-1:0] csr_rd;

  hi_mbox_decode #(.AW(AW)) u_dec (
    .sel_ni(hsel_ni), .write_i(hwrite_i), .addr_i(haddr_i),
    .data_sel_o(data_sel), .csr_sel_o(csr_sel),
    .tx_wr_o(tx_wr), .rx_rd_o(rx_rd), .csr_wr_o(csr_wr)
  );

  hi_mbox_tx_path #(.DW(DW)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_wr_i(tx_wr), .wdata_i(hwdata_i),
    .lrd_i(lrd_i), .hrx_o(lrdata_o), .hrdf_o(hrdf), .txde_o(txde)
  );

  hi_mbox_rx_path #(.DW(DW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .lwr_i(lwr_i), .lwdata_i(lwdata_i),
    .rx_rd_i(rx_rd), .rx_o(rx_word), .rx_full_o(rx_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      treq_q <= 1'b0;
      rreq_q <= 1'b0;
    end else if (csr_wr) begin
      treq_q <= hwdata_i[CSR_TREQ];
      rreq_q <= hwdata_i[CSR_RREQ];
    end
  end

  always_comb begin
    csr_rd           = '0;
    csr_rd[CSR_TREQ] = treq_q;
    csr_rd[CSR_RREQ] = rreq_q;
    csr_rd[CSR_TXDE] = txde;
    csr_rd[CSR_RXF]  = rx_full;
    csr_rd[CSR_HRDF] = hrdf;
    if (csr_sel)       hrdata_o = {{PAD_W{1'b0}}, csr_rd};
    else if (data_sel) hrdata_o = rx_word;
    else               hrdata_o = '0;
  end

  // one request pin shared by both directions
  assign hreq_no    = !((treq_q && txde) || (rreq_q && rx_full));
  assign ldma_req_o = hrdf;

  a_r6_req_drop_on_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && txde && !(rreq_q && rx_full) && !csr_wr) |=> hreq_no);
  a_r9_csr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_wr |=> (treq_q == $past(hwdata_i[CSR_TREQ]) && rreq_q == $past(hwdata_i[CSR_RREQ])));
  a_r10_idle_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsel_ni |=> ($stable(treq_q) && $stable(rreq_q)));
endmodule

// File: tb/hi_mbox_test.sv
`timescale 1ns/1ps
module hi_mbox_test;
  localparam int DW = 32;
  localparam int NV = 4;
  localparam logic [DW-1:0] VEC [NV] = '{32'h0000_0001, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0000_0000};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsel_n = 1'b1, hwrite = 1'b0, lrd = 1'b0, lwr = 1'b0;
  logic [3:0]    haddr = '0;
  logic [DW-1:0] hwdata = '0, lwdata = '0, hrdata, lrdata, rd;
  logic          hreq_n, ldma;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hi_mbox uut (
    .clk_i(clk), .rst_ni(rst_n), .hsel_ni(hsel_n), .hwrite_i(hwrite),
    .haddr_i(haddr), .hwdata_i(hwdata), .hrdata_o(hrdata), .hreq_no(hreq_n),
    .lrd_i(lrd), .lrdata_o(lrdata), .lwr_i(lwr), .lwdata_i(lwdata),
    .ldma_req_o(ldma)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [DW-1:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    hsel_n = sel_n; hwrite = 1'b1; haddr = a; hwdata = d;
    @(negedge clk);
    hsel_n = 1'b1; hwrite = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    hsel_n = 1'b0; hwrite = 1'b0; haddr = a;
    #1 d = hrdata;
    @(negedge clk);
    hsel_n = 1'b1;
  endtask

  task automatic loc_rd();
    @(negedge clk); lrd = 1'b1;
    @(negedge clk); lrd = 1'b0;
  endtask

  task automatic loc_wr(input logic [DW-1:0] d);
    @(negedge clk); lwr = 1'b1; lwdata = d;
    @(negedge clk); lwr = 1'b0;
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hreq_no", {31'b0, hreq_n}, 32'd1);
    check("R1 ldma", {31'b0, ldma}, 32'd0);
    host_rd(4'd1, rd);
    check("R1 status", rd, 32'h4);

    // R9, R6: enable transmit requests
    host_wr(4'd1, 32'h1);
    host_rd(4'd1, rd);
    check("R9 status readback", rd, 32'h5);
    check("R6 hreq low when empty", {31'b0, hreq_n}, 32'd0);

    // vector table: R2, R3, R5, R6 per word
    for (int i = 0; i < NV; i++) begin
      host_wr(4'd0, VEC[i]);
      check("R2 hreq high while tx full", {31'b0, hreq_n}, 32'd1);
      @(negedge clk);
      check("R3 word moved", lrdata, VEC[i]);
      check("R5 ldma set", {31'b0, ldma}, 32'd1);
      check("R6 hreq low again", {31'b0, hreq_n}, 32'd0);
      loc_rd();
      check("R5 ldma cleared", {31'b0, ldma}, 32'd0);
    end

    // R4: local register occupied, next word waits
    host_wr(4'd0, 32'hA1A1_0001);
    @(negedge clk);
    host_wr(4'd0, 32'hB2B2_0002);
    repeat (3) @(negedge clk);
    check("R4 local kept", lrdata, 32'hA1A1_0001);
    check("R4 hreq high, tx waiting", {31'b0, hreq_n}, 32'd1);
    host_rd(4'd1, rd);
    check("R4 status tx full, hrdf", rd, 32'h11);
    host_wr(4'd0, 32'hC3C3_0003);  // R2 ignored while full
    loc_rd();
    @(negedge clk);
    check("R2 waiting word moved, extra ignored", lrdata, 32'hB2B2_0002);
    check("R3 ldma after move", {31'b0, ldma}, 32'd1);
    loc_rd();
    check("R5 drained", {31'b0, ldma}, 32'd0);

    // R7, R8: receive direction only
    host_wr(4'd1, 32'h2);
    check("R7 hreq high rx empty", {31'b0, hreq_n}, 32'd1);
    loc_wr(32'h1234_5678);
    check("R7 hreq low rx full", {31'b0, hreq_n}, 32'd0);
    loc_wr(32'h8765_4321);  // ignored while full
    host_rd(4'd1, rd);
    check("R9 status rx full", rd, 32'hE);
    host_rd(4'd0, rd);
    check("R8 rx data", rd, 32'h1234_5678);
    check("R8 hreq high after read", {31'b0, hreq_n}, 32'd1);
    host_rd(4'd1, rd);
    check("R8 rx flag cleared", rd, 32'h6);

    // R10: unselected and unmapped accesses
    host_wr(4'd0, 32'h5555_AAAA, 1'b1);
    @(negedge clk);
    check("R10 unselected write ignored", {31'b0, ldma}, 32'd0);
    host_wr(4'd1, 32'h3, 1'b1);
    host_wr(4'd5, 32'hFFFF_FFFF);
    host_rd(4'd1, rd);
    check("R10 status unchanged", rd, 32'h6);
    host_rd(4'd5, rd);
    check("R10 unmapped reads zero", rd, 32'h0);
    loc_wr(32'h0BAD_F00D);
    @(negedge clk);
    hsel_n = 1'b1; hwrite = 1'b0; haddr = 4'd0;
    @(negedge clk);
    check("R10 rx kept without select", {31'b0, hreq_n}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule